// File: doc/BRIEF.md
# Device Sync and Delay Stall Unit

This block sits next to an in-order pipeline and looks at one fetched instruction word at a time, qualified by a valid strobe. The word may hold a 16-bit compressed instruction in its low half or a full 32-bit instruction. A word with bits 1:0 not equal to 11 is treated as compressed. The block recognises a small set of custom instructions and holds a stall line high until each one has finished.

Device-sync instructions first ask the memory system for a total-store-order fence and wait for it to drain. The block then watches per-device pending flags for up to five devices that are not memory mapped. A variant picks one of four flag sets: the last read has started, the last read has completed, the last write has started, or the last write has completed. The instruction releases once every device named in its mask has no outstanding condition in that set.

The delay instruction holds the pipeline for an immediate number of cycles. The device interfaces, the load/store unit and the rest of the decoder belong to neighbouring blocks.

Top module: `devSyncStall`

## Requirements
- R1: A compressed sync is recognised when bits 6:0 are 0000001. Bits 15:10 pick the flag set: 100000 waits on read completion (`rdPendDone`), 100001 on read start (`rdPendStart`), 100100 on write start (`wrPendStart`) and 100101 on write completion (`wrPendDone`).
- R2: In a compressed sync, bits 9:7 hold a selector. The selector expands to the device mask as follows: 0 gives 0, 1 to 5 give 1<<(sel-1), 6 gives 01111 and 7 gives 11111. Bit n of the mask names device n.
- R3: A 32-bit sync is recognised when bits 19:0 equal 0x03013. Bits 31:25 pick the flag set: 0001000 is read completion, 0010000 is read start, 0100000 is write start and 1000000 is write completion. Bits 24:20 are the device mask, used unchanged.
- R4: After a sync is accepted, `fenceReq` and `stall` are high from the next cycle on. `fenceReq` stays high until `fenceDone` is sampled high. The device flags are not evaluated before that edge.
- R5: A sync releases at the first edge, at or after the fence edge, where the selected flag set ANDed with the mask is zero. `stall` is low from the following cycle.
- R6: A compressed delay has bits 15:7 all zero and bits 1:0 equal to 10. It holds `stall` high for exactly N cycles, where N is bits 6:2, starting the cycle after acceptance.
- R7: A delay of 0 never raises `stall`. A sync with mask 0, or with no selected flag pending, still performs its fence and releases at the edge where `fenceDone` is sampled.
- R8: A valid word that matches none of the patterns leaves `stall` and `fenceReq` low.
- R9: Instructions are accepted only when the block is idle. A word presented while the block is stalled, or in the single cooldown cycle after a release, is ignored.
- R10: A synchronous active-high `rst` returns the block to idle, clears the delay count and drives `stall` and `fenceReq` low from the next cycle, including in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word; compressed forms use bits 15:0 |
| rdPendStart | input | 5 | Per device: last read not yet started |
| rdPendDone | input | 5 | Per device: last read not yet completed |
| wrPendStart | input | 5 | Per device: last write not yet started |
| wrPendDone | input | 5 | Per device: last write not yet completed |
| fenceDone | input | 1 | Memory ordering fence has drained |
| fenceReq | output | 1 | Fence request, high while waiting for the fence |
| stall | output | 1 | Hold the pipeline |

## Verification
A corrupted controller state shows on `stall` or `fenceReq` one cycle after the edge that corrupted it, because both outputs come directly from the state register. Some errors cannot show until the release condition is reached: a wrong latched mask, a wrong flag-set choice or a miscounted delay. They then appear as a `stall` that falls too early or too late, at the cycle where the flags clear or the count ends. The reference model is therefore compared on every cycle, and the flag sets that were not selected are held pending, so that picking the wrong set leaves a visible stall.

// File: rtl/devsync_pkg.sv
package devsync_pkg;

  typedef enum logic [1:0] {
    WAIT_RD_DONE  = 2'd0,
    WAIT_RD_START = 2'd1,
    WAIT_WR_START = 2'd2,
    WAIT_WR_DONE  = 2'd3
  } waitKind_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FENCE   = 3'd1,
    ST_DEVWAIT = 3'd2,
    ST_DELAY   = 3'd3,
    ST_DONE    = 3'd4
  } ctrlState_e;

  typedef struct packed {
    logic loadSync;
    logic loadDelay;
    logic countDown;
  } ctrlStrobe_t;

endpackage

// File: rtl/devSyncDatapath.sv
module devSyncDatapath
  import devsync_pkg::*;
#(
  parameter int DEV_W = 5,
  parameter int CNT_W = 5,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [31:0]       instrWord,
  input  logic [DEV_W-1:0]  rdPendStart,
  input  logic [DEV_W-1:0]  rdPendDone,
  input  logic [DEV_W-1:0]  wrPendStart,
  input  logic [DEV_W-1:0]  wrPendDone,
  input  ctrlStrobe_t       strobe,
  output logic              decSync,
  output logic              decDelay,
  output logic              decDelayZero,
  output logic              waitMet,
  output logic              cntLast
);

  localparam logic [19:0] SYNC32_LOW = 20'h03013;
  localparam int MASK_LSB = 20;
  localparam int SEL_LSB  = 7;
  localparam int CNT_LSB  = 2;

  function automatic logic [DEV_W-1:0] expandSel(input logic [SEL_W-1:0] s);
    logic [DEV_W-1:0] r;
    int sv;
    sv = int'(s);
    if (sv == 0)          r = '0;
    else if (sv <= DEV_W) r = DEV_W'(1) << (sv - 1);
    else                  r = (DEV_W'(1) << (sv - 2)) - DEV_W'(1);
    return r;
  endfunction

  // decode
  logic      hit16, hit32, hitDelay;
  waitKind_e kind16, kind32, decKind;
  logic [DEV_W-1:0] decMask;
  logic [SEL_W-1:0] selField;

  assign selField = instrWord[SEL_LSB +: SEL_W];

  always_comb begin
    hit16  = 1'b0;
    kind16 = WAIT_RD_DONE;
    if (instrWord[6:0] == 7'b0000001) begin
      case (instrWord[15:10])
        6'b100000: begin hit16 = 1'b1; kind16 = WAIT_RD_DONE;  end
        6'b100001: begin hit16 = 1'b1; kind16 = WAIT_RD_START; end
        6'b100100: begin hit16 = 1'b1; kind16 = WAIT_WR_START; end
        6'b100101: begin hit16 = 1'b1; kind16 = WAIT_WR_DONE;  end
        default:   hit16 = 1'b0;
      endcase
    end
  end

  always_comb begin
    hit32  = 1'b0;
    kind32 = WAIT_RD_DONE;
    if (instrWord[19:0] == SYNC32_LOW) begin
      case (instrWord[31:25])
        7'b0001000: begin hit32 = 1'b1; kind32 = WAIT_RD_DONE;  end
        7'b0010000: begin hit32 = 1'b1; kind32 = WAIT_RD_START; end
        7'b0100000: begin hit32 = 1'b1; kind32 = WAIT_WR_START; end
        7'b1000000: begin hit32 = 1'b1; kind32 = WAIT_WR_DONE;  end
        default:    hit32 = 1'b0;
      endcase
    end
  end

  assign hitDelay     = (instrWord[15:7] == 9'd0) && (instrWord[1:0] == 2'b10);
  assign decKind      = hit32 ? kind32 : kind16;
  assign decMask      = hit32 ? instrWord[MASK_LSB +: DEV_W] : expandSel(selField);
  assign decSync      = instrValid && (hit16 || hit32);
  assign decDelay     = instrValid && hitDelay;
  assign decDelayZero = (instrWord[CNT_LSB +: CNT_W] == '0);

  // latched operation
  waitKind_e        opKind;
  logic [DEV_W-1:0] opMask;
  logic [CNT_W-1:0] delayCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      opKind   <= WAIT_RD_DONE;
      opMask   <= '0;
      delayCnt <= '0;
    end else begin
      if (strobe.loadSync) begin
        opKind <= decKind;
        opMask <= decMask;
      end
      if (strobe.loadDelay)
        delayCnt <= instrWord[CNT_LSB +: CNT_W];
      else if (strobe.countDown)
        delayCnt <= delayCnt - CNT_W'(1);
    end
  end

  // per-device flag selection
  logic [DEV_W-1:0] pendSel;
  for (genvar g = 0; g < DEV_W; g++) begin : gDev
    assign pendSel[g] = (opKind == WAIT_RD_START) ? rdPendStart[g] :
                        (opKind == WAIT_RD_DONE)  ? rdPendDone[g]  :
                        (opKind == WAIT_WR_START) ? wrPendStart[g] :
                                                    wrPendDone[g];
  end

  assign waitMet = ((pendSel & opMask) == '0);
  assign cntLast = (delayCnt == CNT_W'(1));

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (hit16 && !hit32 && selField != '0 && int'(selField) <= DEV_W) |-> ($countones(decMask) == 1)); // R2
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    strobe.countDown |-> (delayCnt != '0)); // R6
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(strobe.loadSync && strobe.loadDelay)); // R9

endmodule

// File: rtl/devSyncCtrl.sv
module devSyncCtrl
  import devsync_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        decSync,
  input  logic        decDelay,
  input  logic        decDelayZero,
  input  logic        fenceDone,
  input  logic        waitMet,
  input  logic        cntLast,
  output ctrlStrobe_t strobe,
  output logic        stall,
  output logic        fenceReq
);

  ctrlState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (decSync) begin
          strobe.loadSync = 1'b1;
          stateNext       = ST_FENCE;
        end else if (decDelay) begin
          strobe.loadDelay = 1'b1;
          stateNext        = decDelayZero ? ST_DONE : ST_DELAY;
        end
      end
      ST_FENCE: begin
        if (fenceDone) stateNext = waitMet ? ST_DONE : ST_DEVWAIT;
      end
      ST_DEVWAIT: begin
        if (waitMet) stateNext = ST_DONE;
      end
      ST_DELAY: begin
        if (cntLast) stateNext = ST_DONE;
        else         strobe.countDown = 1'b1;
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign stall    = (state == ST_FENCE) || (state == ST_DEVWAIT) || (state == ST_DELAY);
  assign fenceReq = (state == ST_FENCE);

  AST_FENCE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fenceReq && !fenceDone) |=> fenceReq); // R4
  AST_DEVWAIT_AFTER_FENCE: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_DEVWAIT) && !$past(state == ST_DEVWAIT)) |-> $past(fenceReq && fenceDone)); // R4
  AST_DEVWAIT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_DEVWAIT) && waitMet) |=> !stall); // R5
  AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_DELAY) && !cntLast) |=> stall); // R6
  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !decSync && decDelay && decDelayZero) |=> !stall); // R7
  AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !decSync && !decDelay) |=> (!stall && !fenceReq)); // R8
  AST_DONE_COOLDOWN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!stall && !fenceReq)); // R10

endmodule

// File: rtl/devSyncStall.sv
module devSyncStall
  import devsync_pkg::*;
#(
  parameter int DEV_W = 5,
  parameter int CNT_W = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instrValid,
  input  logic [31:0]      instrWord,
  input  logic [DEV_W-1:0] rdPendStart,
  input  logic [DEV_W-1:0] rdPendDone,
  input  logic [DEV_W-1:0] wrPendStart,
  input  logic [DEV_W-1:0] wrPendDone,
  input  logic             fenceDone,
  output logic             fenceReq,
  output logic             stall
);

  ctrlStrobe_t strobe;
  logic decSync, decDelay, decDelayZero, waitMet, cntLast;

  devSyncDatapath #(.DEV_W(DEV_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) dp_i (
    .clk(clk), .rst(rst),
    .instrValid(instrValid), .instrWord(instrWord),
    .rdPendStart(rdPendStart), .rdPendDone(rdPendDone),
    .wrPendStart(wrPendStart), .wrPendDone(wrPendDone),
    .strobe(strobe),
    .decSync(decSync), .decDelay(decDelay), .decDelayZero(decDelayZero),
    .waitMet(waitMet), .cntLast(cntLast)
  );

  devSyncCtrl ctrl_i (
    .clk(clk), .rst(rst),
    .decSync(decSync), .decDelay(decDelay), .decDelayZero(decDelayZero),
    .fenceDone(fenceDone), .waitMet(waitMet), .cntLast(cntLast),
    .strobe(strobe), .stall(stall), .fenceReq(fenceReq)
  );

endmodule

// File: tb/devSyncStall_tb_top.sv
`timescale 1ns/1ps
module devSyncStall_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = 32'h0;
  logic [4:0]  rdPS = 5'h0, rdPD = 5'h0, wrPS = 5'h0, wrPD = 5'h0;
  logic        fenceDone = 1'b0;
  logic        fenceReq, stall;

  devSyncStall dut_i (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .rdPendStart(rdPS), .rdPendDone(rdPD), .wrPendStart(wrPS), .wrPendDone(wrPD),
    .fenceDone(fenceDone), .fenceReq(fenceReq), .stall(stall)
  );

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string curReq = "R10";

  // reference model: 0 idle, 1 fencing, 2 device wait, 3 delaying, 4 cooldown
  int         mMode = 0;
  int         mLeft = 0;
  int         mVec  = 0;
  logic [4:0] mMask = 5'h0;

  function automatic logic [4:0] selTable(input logic [2:0] s);
    case (s)
      3'd0: return 5'd0;
      3'd1: return 5'd1;
      3'd2: return 5'd2;
      3'd3: return 5'd4;
      3'd4: return 5'd8;
      3'd5: return 5'd16;
      3'd6: return 5'd15;
      default: return 5'd31;
    endcase
  endfunction

  function automatic logic [4:0] pendOf(input int v);
    case (v)
      0: return rdPS;
      1: return rdPD;
      2: return wrPS;
      default: return wrPD;
    endcase
  endfunction

  // kind: 0 none, 1 sync, 2 delay; vec: 0 rdStart, 1 rdDone, 2 wrStart, 3 wrDone
  task automatic mdlDecode(input logic [31:0] w, output int kind, output int vec,
                           output logic [4:0] m, output int n);
    kind = 0; vec = 0; m = 5'h0; n = 0;
    if (w[1:0] == 2'b11) begin
      if (w[19:0] == 20'h03013) begin
        m = w[24:20];
        case (w[31:25])
          7'h08: begin kind = 1; vec = 1; end
          7'h10: begin kind = 1; vec = 0; end
          7'h20: begin kind = 1; vec = 2; end
          7'h40: begin kind = 1; vec = 3; end
          default: kind = 0;
        endcase
      end
    end else if (w[6:0] == 7'h01) begin
      m = selTable(w[9:7]);
      case (w[15:10])
        6'h20: begin kind = 1; vec = 1; end
        6'h21: begin kind = 1; vec = 0; end
        6'h24: begin kind = 1; vec = 2; end
        6'h25: begin kind = 1; vec = 3; end
        default: kind = 0;
      endcase
    end else if (w[15:7] == 9'd0 && w[1:0] == 2'b10) begin
      kind = 2;
      n = int'(w[6:2]);
    end
  endtask

  always @(posedge clk) begin
    int k, v, n;
    logic [4:0] m;
    cycles++;
    if (rst) begin
      mMode = 0; mLeft = 0;
    end else begin
      case (mMode)
        0: if (instrValid) begin
             mdlDecode(instrWord, k, v, m, n);
             if (k == 1) begin mMode = 1; mVec = v; mMask = m; end
             else if (k == 2) begin
               if (n == 0) mMode = 4;
               else begin mMode = 3; mLeft = n; end
             end
           end
        1: if (fenceDone) mMode = ((pendOf(mVec) & mMask) == 5'h0) ? 4 : 2;
        2: if ((pendOf(mVec) & mMask) == 5'h0) mMode = 4;
        3: begin mLeft--; if (mLeft == 0) mMode = 4; end
        default: mMode = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    logic es, ef;
    if (!finished) begin
      es = (mMode >= 1 && mMode <= 3);
      ef = (mMode == 1);
      vectors++;
      if (stall !== es || fenceReq !== ef) begin
        miscompares++;
        $display("FAIL %s cycle %0d: stall=%b fenceReq=%b expected stall=%b fenceReq=%b",
                 curReq, cycles, stall, fenceReq, es, ef);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [31:0] c16(input logic [5:0] f, input logic [2:0] s);
    return {16'h0, f, s, 7'b0000001};
  endfunction
  function automatic logic [31:0] c32(input logic [6:0] f, input logic [4:0] m);
    return {f, m, 20'h03013};
  endfunction
  function automatic logic [31:0] dly(input logic [4:0] n);
    return {16'h0, 9'h0, n, 2'b10};
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] w);
    instrValid = 1'b1; instrWord = w;
    @(negedge clk);
    instrValid = 1'b0; instrWord = 32'h0;
  endtask

  task automatic setPend(input int v, input logic [4:0] p);
    rdPS = (v == 0) ? p : 5'h1f;
    rdPD = (v == 1) ? p : 5'h1f;
    wrPS = (v == 2) ? p : 5'h1f;
    wrPD = (v == 3) ? p : 5'h1f;
  endtask

  task automatic clearAll();
    rdPS = 5'h0; rdPD = 5'h0; wrPS = 5'h0; wrPD = 5'h0;
  endtask

  task automatic syncRun(input logic [31:0] w, input int v, input logic [4:0] p,
                         input int fLat, input int hold);
    setPend(v, p);
    issue(w);
    ticks(fLat);
    fenceDone = 1'b1;
    ticks(1);
    fenceDone = 1'b0;
    ticks(hold);
    case (v)
      0: rdPS = 5'h0;
      1: rdPD = 5'h0;
      2: wrPS = 5'h0;
      default: wrPD = 5'h0;
    endcase
    ticks(3);
    clearAll();
    ticks(1);
  endtask

  initial begin
    // R10: reset state
    curReq = "R10";
    ticks(4);
    rst = 1'b0;
    ticks(2);

    // R1: compressed variants select their flag set
    curReq = "R1";
    syncRun(c16(6'b100000, 3'd3), 1, 5'b00100, 2, 4);
    syncRun(c16(6'b100001, 3'd1), 0, 5'b00001, 1, 3);
    syncRun(c16(6'b100100, 3'd4), 2, 5'b01000, 3, 2);
    syncRun(c16(6'b100101, 3'd5), 3, 5'b10000, 2, 5);

    // R2: selector expansion
    curReq = "R2";
    syncRun(c16(6'b100001, 3'd6), 0, 5'b10000, 2, 4);
    syncRun(c16(6'b100001, 3'd7), 0, 5'b10000, 2, 4);
    syncRun(c16(6'b100000, 3'd2), 1, 5'b00010, 1, 3);
    syncRun(c16(6'b100100, 3'd2), 2, 5'b00001, 1, 3);

    // R3: 32-bit forms, mask used directly
    curReq = "R3";
    syncRun(c32(7'b0001000, 5'b10101), 1, 5'b00100, 2, 3);
    syncRun(c32(7'b0010000, 5'b00011), 0, 5'b00010, 1, 4);
    syncRun(c32(7'b0100000, 5'b11000), 2, 5'b10000, 3, 2);
    syncRun(c32(7'b1000000, 5'b01110), 3, 5'b00110, 2, 3);
    syncRun(c32(7'b0100000, 5'b00110), 2, 5'b11001, 2, 3);

    // R4: long fence, fenceDone while idle has no effect
    curReq = "R4";
    syncRun(c32(7'b0001000, 5'b00001), 1, 5'b00001, 7, 2);
    fenceDone = 1'b1;
    ticks(3);
    fenceDone = 1'b0;
    ticks(2);

    // R5: multi-device release
    curReq = "R5";
    syncRun(c32(7'b1000000, 5'b11111), 3, 5'b11111, 1, 6);
    syncRun(c16(6'b100101, 3'd7), 3, 5'b01010, 0, 4);

    // R6: delays
    curReq = "R6";
    issue(dly(5'd1));  ticks(4);
    issue(dly(5'd5));  ticks(8);
    issue(dly(5'd31)); ticks(34);

    // R7: zero count and zero mask
    curReq = "R7";
    issue(dly(5'd0)); ticks(3);
    syncRun(c16(6'b100000, 3'd0), 1, 5'b11111, 2, 2);
    syncRun(c32(7'b0010000, 5'b00000), 0, 5'b11111, 3, 2);

    // R8: unrecognised words
    curReq = "R8";
    issue(c16(6'b100010, 3'd3)); ticks(2);
    issue(c32(7'b0000001, 5'h1f)); ticks(2);
    issue({16'h0, 9'b000000001, 5'd3, 2'b10}); ticks(2);
    issue({7'b0001000, 5'h1f, 20'h03093}); ticks(2);
    issue(32'hffff_ffff); ticks(2);

    // R9: words while busy or in cooldown are ignored
    curReq = "R9";
    issue(dly(5'd6));
    ticks(2);
    issue(dly(5'd10));
    ticks(8);
    issue(dly(5'd3));
    ticks(3);
    issue(dly(5'd2));
    ticks(6);
    setPend(1, 5'b00001);
    issue(c16(6'b100000, 3'd1));
    issue(dly(5'd4));
    ticks(2);
    fenceDone = 1'b1; ticks(1); fenceDone = 1'b0;
    ticks(2);
    rdPD = 5'h0;
    ticks(3);
    clearAll();
    ticks(2);

    // R10: reset in the middle of operations
    curReq = "R10";
    issue(dly(5'd20));
    ticks(4);
    rst = 1'b1; ticks(2); rst = 1'b0;
    ticks(3);
    setPend(2, 5'b00011);
    issue(c16(6'b100100, 3'd6));
    ticks(2);
    rst = 1'b1; ticks(1); rst = 1'b0;
    clearAll();
    ticks(3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule